// File: doc/BRIEF.md
# Cascaded Six-Channel Converter Readout Controller

This block sits on the host side of two six-channel sampling converters wired in a cascade. The far converter's serial outputs feed the near converter's serial inputs, and the near converter's outputs reach the host. On a start request the block raises a shared conversion-start line, which samples all twelve analog inputs at the same instant. It then waits for the busy line to fall.

Once the conversion is complete, the block runs one serial read framed by an active-low chip-select. It generates the serial clock with a divider and samples the data lines on the falling edges of that clock. The interleaved 16-bit slots are sorted into twelve 12-bit channel registers. When the frame closes, a one-cycle done pulse tells the consumer that all twelve results are fresh.

The build-time parameter `LINES` selects the number of data lines, either two or three. This parameter fixes both the frame length and the slot-to-channel map.

Top module: `daisy_adc_reader`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o` is 1, `conv_o` is 0, `done_o` is 0 and all twelve results are zero.
- R2: When `start_i` is sampled high while the block is idle, `conv_o` is 1 on the following cycle. It stays 1 until `busy_i` has been high and then falls.
- R3: `cs_n_o` goes low only after `busy_i` has fallen, and never while `busy_i` is high.
- R4: A frame has 16*12/LINES falling edges of `sclk_o` while `cs_n_o` is low: 96 edges with two lines and 64 with three.
- R5: `sclk_o` idles high whenever `cs_n_o` is high. The first falling edge comes DIV cycles after `cs_n_o` falls, and each later falling edge comes 2*DIV cycles after the previous one.
- R6: With two lines, every line carries 16-bit slots MSB first. The near device's slots come first, then the far device's. Line 0 carries channels 1, 2, 5 and line 1 carries channels 3, 4, 6 of each device. Result index k is 0..5 for the near device and 6..11 for the far device, and result k sits at `res_o[12k+11:12k]`.
- R7: With three lines, the slot order is the same, with line 0 carrying channels 1 and 2, line 1 carrying channels 3 and 4, and line 2 carrying channels 5 and 6 of each device.
- R8: Each stored result is the low 12 bits of its 16-bit slot. The upper 4 bits are discarded.
- R9: `done_o` is high for exactly one cycle, in the cycle in which `cs_n_o` returns high. All twelve results already hold the new frame in that cycle.
- R10: A `start_i` pulse during a conversion or a read has no effect. No further `conv_o` rise and no second frame follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to convert and read |
| conv_o | output | 1 | Shared conversion-start output, rising edge starts conversion |
| busy_i | input | 1 | Conversion in progress, from the converters |
| cs_n_o | output | 1 | Active-low frame select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdi_i | input | LINES | Serial data lines from the near device |
| res_o | output | 144 | Twelve 12-bit results, channel k at bits 12k+11:12k |
| done_o | output | 1 | One-cycle pulse when a frame has been stored |

## Verification
`conv_o` is registered, so it is due one cycle after `start_i` is sampled. The bench drives `start_i` on a falling clock edge and checks `conv_o` on the next falling edge.

Serial timing is checked by counting system cycles between falling clock edges. The bench counts DIV cycles from the fall of `cs_n_o` to the first `sclk_o` fall, and 2*DIV cycles between later falls, with every observation taken on the falling system-clock edge.

The results are compared only once `done_o` has been seen, because they are complete by that cycle. To check that an ignored start has no effect, the bench watches for several hundred cycles after the frame and confirms that no further conversion or frame occurs.

// File: rtl/daisy_adc_reader.sv
module daisy_adc_reader #(
  parameter int LINES = 2,
  parameter int DIV   = 2,
  parameter int RES   = 12,
  parameter int SLOT  = 16,
  parameter int NCH   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic                 conv_o,
  input  logic                 busy_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  input  logic [LINES-1:0]     sdi_i,
  output logic [NCH*RES-1:0]   res_o,
  output logic                 done_o
);
  localparam int FRAME = SLOT * NCH / LINES;
  localparam int PER   = NCH / 2;
  localparam int SPL   = PER / LINES;
  localparam int BW    = $clog2(FRAME + 1);
  localparam int DCW   = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_BUSY, S_READ} state_t;
  state_t state;

  logic [DCW-1:0] div_q;
  logic [BW-1:0]  bits_q;
  logic [RES-2:0] sh [LINES];
  logic [RES-1:0] res [NCH];

  function automatic int chan_of(input int ln, input int sl);
    int dev, s, ch;
    dev = sl / SPL;
    s   = sl % SPL;
    if (LINES == 2)
      ch = (ln == 0) ? ((s == 2) ? 4 : s) : ((s == 2) ? 5 : s + 2);
    else
      ch = ln * 2 + s;
    return dev * PER + ch;
  endfunction

  wire tick      = (div_q == DCW'(DIV - 1));
  wire slot_end  = (int'(bits_q) % SLOT) == (SLOT - 1);
  wire last_edge = (bits_q == BW'(FRAME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      conv_o <= 1'b0;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b1;
      done_o <= 1'b0;
      div_q  <= '0;
      bits_q <= '0;
      for (int l = 0; l < LINES; l++) sh[l] <= '0;
      for (int k = 0; k < NCH; k++) res[k] <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          conv_o <= 1'b1;
          state  <= S_CONV;
        end
        S_CONV: if (busy_i) state <= S_BUSY;
        S_BUSY: if (!busy_i) begin
          conv_o <= 1'b0;
          cs_n_o <= 1'b0;
          div_q  <= '0;
          bits_q <= '0;
          state  <= S_READ;
        end
        S_READ: begin
          if (!tick) begin
            div_q <= div_q + 1'b1;
          end else begin
            div_q <= '0;
            if (sclk_o) begin
              sclk_o <= 1'b0;
              bits_q <= bits_q + 1'b1;
              for (int l = 0; l < LINES; l++) begin
                sh[l] <= {sh[l][RES-3:0], sdi_i[l]};
                if (slot_end)
                  res[chan_of(l, int'(bits_q) / SLOT)] <= {sh[l], sdi_i[l]};
              end
            end else begin
              sclk_o <= 1'b1;
              if (last_edge) begin
                cs_n_o <= 1'b1;
                done_o <= 1'b1;
                state  <= S_IDLE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_out
    assign res_o[k*RES +: RES] = res[k];
  end
endmodule

// File: rtl/daisy_adc_reader_chk.sv
module daisy_adc_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_o,
  input logic busy_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic done_o
);
  // R3
  read_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !busy_i);
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_n_o));
  // R10
  conv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_o) |-> cs_n_o);
  // R2
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_o && busy_i) |=> conv_o);
endmodule

bind daisy_adc_reader daisy_adc_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_o(conv_o), .busy_i(busy_i),
  .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o)
);

// File: tb/daisy_adc_reader_test.sv
module daisy_adc_reader_test;
  localparam int DIV = 2;
  localparam int BUSYLEN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // two-line unit
  logic start_a = 1'b0, busy_a = 1'b0, conv_a, cs_a, sclk_a, done_a;
  logic [1:0] sdi_a;
  logic [143:0] res_a;
  // three-line unit
  logic start_b = 1'b0, busy_b = 1'b0, conv_b, cs_b, sclk_b, done_b;
  logic [2:0] sdi_b;
  logic [143:0] res_b;

  daisy_adc_reader #(.LINES(2), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .conv_o(conv_a), .busy_i(busy_a),
    .cs_n_o(cs_a), .sclk_o(sclk_a), .sdi_i(sdi_a), .res_o(res_a), .done_o(done_a));

  daisy_adc_reader #(.LINES(3), .DIV(DIV)) uut_b (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .conv_o(conv_b), .busy_i(busy_b),
    .cs_n_o(cs_b), .sclk_o(sclk_b), .sdi_i(sdi_b), .res_o(res_b), .done_o(done_b));

  logic [15:0] word [12];
  logic [95:0] str_a [2];
  logic [63:0] str_b [3];

  function automatic int map2(input int ln, input int sl);
    int t0 [6] = '{0, 1, 4, 6, 7, 10};
    int t1 [6] = '{2, 3, 5, 8, 9, 11};
    return (ln == 0) ? t0[sl] : t1[sl];
  endfunction

  function automatic int map3(input int ln, input int sl);
    int dev = sl / 2;
    return dev * 6 + ln * 2 + (sl % 2);
  endfunction

  task automatic load(input int seed);
    for (int k = 0; k < 12; k++)
      word[k] = 16'((seed * 16'h3A7 + k * 16'h1F3) ^ ((k + seed) << 12));
    word[3] = {4'hF, word[3][11:0]};
    for (int l = 0; l < 2; l++)
      for (int s = 0; s < 6; s++) str_a[l][95 - 16*s -: 16] = word[map2(l, s)];
    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 4; s++) str_b[l][63 - 16*s -: 16] = word[map3(l, s)];
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitors and converter models, per unit
  int idx_a = 0, falls_a = 0, dones_a = 0, convr_a = 0, gap_err_a = 0, bad_a = 0, csf_a = 0, lastf_a = 0, first_a = 0;
  logic ps_a = 1'b1, pc_a = 1'b1, pcv_a = 1'b0;
  int bcnt_a = 0;
  always @(negedge clk) begin
    cyc++;
    if (conv_a && !pcv_a) begin convr_a++; bcnt_a = 1; end
    if (bcnt_a > 0) begin
      bcnt_a++;
      busy_a = (bcnt_a > 3 && bcnt_a < 3 + BUSYLEN);
      if (bcnt_a >= 3 + BUSYLEN) bcnt_a = 0;
    end
    if (!cs_a && busy_a) bad_a++;
    if (conv_a == 1'b0 && pcv_a && busy_a) bad_a++;
    if (!cs_a && pc_a) begin csf_a = cyc; first_a = 1; end
    if (!cs_a && ps_a && !sclk_a) begin
      falls_a++;
      if (first_a == 1) begin
        if (cyc - csf_a != DIV) gap_err_a++;
        first_a = 0;
      end else if (cyc - lastf_a != 2*DIV) gap_err_a++;
      lastf_a = cyc;
    end
    if (cs_a) idx_a = 0;
    else if (sclk_a && !ps_a) idx_a++;
    for (int l = 0; l < 2; l++) sdi_a[l] = (idx_a < 96) ? str_a[l][95 - idx_a] : 1'b0;
    if (done_a) dones_a++;
    ps_a = sclk_a; pc_a = cs_a; pcv_a = conv_a;
  end

  int idx_b = 0, falls_b = 0, dones_b = 0, convr_b = 0, gap_err_b = 0, bad_b = 0, csf_b = 0, lastf_b = 0, first_b = 0;
  logic ps_b = 1'b1, pc_b = 1'b1, pcv_b = 1'b0;
  int bcnt_b = 0;
  always @(negedge clk) begin
    if (conv_b && !pcv_b) begin convr_b++; bcnt_b = 1; end
    if (bcnt_b > 0) begin
      bcnt_b++;
      busy_b = (bcnt_b > 3 && bcnt_b < 3 + BUSYLEN);
      if (bcnt_b >= 3 + BUSYLEN) bcnt_b = 0;
    end
    if (!cs_b && busy_b) bad_b++;
    if (!cs_b && pc_b) begin csf_b = cyc; first_b = 1; end
    if (!cs_b && ps_b && !sclk_b) begin
      falls_b++;
      if (first_b == 1) begin
        if (cyc - csf_b != DIV) gap_err_b++;
        first_b = 0;
      end else if (cyc - lastf_b != 2*DIV) gap_err_b++;
      lastf_b = cyc;
    end
    if (cs_b) idx_b = 0;
    else if (sclk_b && !ps_b) idx_b++;
    for (int l = 0; l < 3; l++) sdi_b[l] = (idx_b < 64) ? str_b[l][63 - idx_b] : 1'b0;
    if (done_b) dones_b++;
    ps_b = sclk_b; pc_b = cs_b; pcv_b = conv_b;
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cs_a && sclk_a && !conv_a && !done_a, "R1 idle outputs", {cs_a, sclk_a, conv_a, done_a}, 4'b1100);
    chk(res_a == '0 && res_b == '0, "R1 results zero", int'(res_a[31:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_b && sclk_b && !conv_b, "R1 idle after release", {cs_b, sclk_b, conv_b}, 3'b110);
  endtask

  task automatic t_frame_a(input int seed, input logic poke);
    load(seed);
    falls_a = 0; dones_a = 0; convr_a = 0; gap_err_a = 0; bad_a = 0;
    start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    chk(conv_a, "R2 conv rises next cycle", conv_a, 1);
    for (int i = 0; i < 2000 && dones_a == 0; i++) begin
      @(negedge clk);
      if (poke && !cs_a && falls_a == 10) start_a = 1'b1;
      else start_a = 1'b0;
    end
    start_a = 1'b0;
    chk(dones_a == 1, "R9 done seen", dones_a, 1);
    chk(cs_a, "R9 cs released with done", cs_a, 1);
    for (int k = 0; k < 12; k++)
      chk(res_a[12*k +: 12] == word[k][11:0], "R6 two-line channel", int'(res_a[12*k +: 12]), int'(word[k][11:0]));
    chk(res_a[36 +: 12] == word[3][11:0], "R8 upper bits dropped", int'(res_a[36 +: 12]), int'(word[3][11:0]));
    chk(falls_a == 96, "R4 two-line frame length", falls_a, 96);
    chk(gap_err_a == 0, "R5 sclk spacing", gap_err_a, 0);
    chk(bad_a == 0, "R3 R2 read after busy, conv held", bad_a, 0);
    @(negedge clk);
    chk(!done_a, "R9 done one cycle", done_a, 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      chk(convr_a == 1 && cs_a && dones_a == 1, "R10 start during read ignored", convr_a, 1);
    end
  endtask

  task automatic t_frame_b(input int seed);
    load(seed);
    falls_b = 0; dones_b = 0; convr_b = 0; gap_err_b = 0; bad_b = 0;
    start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    chk(conv_b, "R2 conv rises next cycle", conv_b, 1);
    @(negedge clk);
    start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    for (int i = 0; i < 2000 && dones_b == 0; i++) @(negedge clk);
    chk(dones_b == 1, "R9 done seen", dones_b, 1);
    for (int k = 0; k < 12; k++)
      chk(res_b[12*k +: 12] == word[k][11:0], "R7 three-line channel", int'(res_b[12*k +: 12]), int'(word[k][11:0]));
    chk(falls_b == 64, "R4 three-line frame length", falls_b, 64);
    chk(gap_err_b == 0, "R5 sclk spacing", gap_err_b, 0);
    chk(bad_b == 0, "R3 cs low during busy", bad_b, 0);
    repeat (200) @(negedge clk);
    chk(convr_b == 1 && dones_b == 1, "R10 start during conversion ignored", convr_b, 1);
  endtask

  initial begin
    t_reset();
    t_frame_a(1, 1'b0);
    t_frame_a(7, 1'b1);
    t_frame_a(23, 1'b0);
    t_frame_b(5);
    t_frame_b(42);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule